// File: doc/BRIEF.md
# Dual-Policy Cache Way Replacement Unit

This block tracks replacement history for every set of an N-way set-associative cache and names the way to evict when a new block has to be placed. The cache reports each access, hit or allocation, as a touch (set index plus way). It asks for a victim by presenting a set index and that set's per-way valid vector. If any way is invalid, the lowest-numbered invalid way is returned. Only when the set is full does the replacement policy decide.

A static select input picks the policy. The first is exact LRU, which keeps a log2(N)-bit age rank for each way. The second is tree pseudo-LRU, which keeps N−1 direction bits per set arranged as a binary tree. Both histories are updated on every touch, so the select input only chooses which history answers a query. The victim answer is combinational from the stored state. A touch becomes visible to queries from the following cycle.

Top module: `repl_unit`

## Requirements
- R1: `policy_sel` = 0 selects exact LRU and `policy_sel` = 1 selects tree pseudo-LRU. The input is held constant while out of reset.
- R2: When `query_valid` has at least one zero bit, `victim_way` is the lowest index whose valid bit is 0, whatever the policy.
- R3: Under LRU with all ways valid, `victim_way` is the way whose most recent touch in that set is oldest.
- R4: An LRU touch makes the touched way rank 0 (newest). Ways whose rank was below the touched way's rank age by one. All other ranks and all other sets are unchanged.
- R5: Each set holds N−1 tree bits, with node 1 as the root and node k having children 2k and 2k+1. A bit value of 1 steers toward the upper-numbered half. A touch walks from the root using the way index MSB first, and sets each node on the path to point away from the touched way.
- R6: Under pseudo-LRU with all ways valid, `victim_way` is found by following the tree bits from the root, taking each bit as the next way-index bit, MSB first.
- R7: After reset, way i of every set holds LRU rank i and all tree bits are 0. A full set therefore yields way N−1 under LRU and way 0 under pseudo-LRU.
- R8: `victim_way` reflects the stored state in the same cycle as the query inputs. A touch sampled at a rising edge affects queries from the cycle after that edge.
- R9: With `touch_valid` low, no replacement state changes, whatever the values on `touch_set` and `touch_way`.
- R10: Under either policy, a full-set query in the cycle after a touch of that set never returns the way just touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_sel | input | 1 | 0 = LRU, 1 = tree pseudo-LRU (static) |
| touch_valid | input | 1 | An access to report this cycle |
| touch_set | input | $clog2(NUM_SETS) | Set of the reported access |
| touch_way | input | $clog2(NUM_WAYS) | Way hit or allocated |
| query_set | input | $clog2(NUM_SETS) | Set being asked for a victim |
| query_valid | input | NUM_WAYS | Valid bit of each way in the queried set |
| victim_way | output | $clog2(NUM_WAYS) | Way to fill or evict |

## Verification
The victim answer has zero cycles of latency, and a touch takes effect one edge later. The bench therefore drives the touch and the query together on the falling edge and compares `victim_way` 1 ns later against the model state from before that touch. It applies the touch to its model only after the next rising edge. Queries that are meant to observe a touch, or an ignored touch, are placed one cycle later. The reset state, invalid-way priority, hand-worked tree walks and random traffic under both policies are all scored this way.

// File: rtl/repl_pkg.sv
package repl_pkg;
  typedef enum logic {
    POL_LRU  = 1'b0,
    POL_PLRU = 1'b1
  } repl_policy_e;
endpackage

// File: rtl/lru_rank_store.sv
module lru_rank_store #(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  localparam int WW = $clog2(NUM_WAYS),
  localparam int SW = $clog2(NUM_SETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [SW-1:0] touch_set,
  input  logic [WW-1:0] touch_way,
  input  logic [SW-1:0] query_set,
  output logic [WW-1:0] oldest_way
);
  logic [NUM_WAYS*WW-1:0] rank_q [NUM_SETS];
  logic [NUM_WAYS*WW-1:0] row_cur, row_nxt, row_qry;
  logic [WW-1:0]          hit_rank;

  // next-state for the touched row
  always_comb begin
    row_cur  = rank_q[touch_set];
    hit_rank = row_cur[touch_way*WW +: WW];
    row_nxt  = row_cur;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (WW'(w) == touch_way)
        row_nxt[w*WW +: WW] = '0;
      else if (row_cur[w*WW +: WW] < hit_rank)
        row_nxt[w*WW +: WW] = row_cur[w*WW +: WW] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WAYS; w++)
          rank_q[s][w*WW +: WW] <= WW'(w);
    end else if (touch_en) begin
      rank_q[touch_set] <= row_nxt;
    end
  end

  always_comb begin
    row_qry    = rank_q[query_set];
    oldest_way = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (row_qry[w*WW +: WW] == WW'(NUM_WAYS-1))
        oldest_way = WW'(w);
  end
endmodule

// File: rtl/plru_tree_store.sv
module plru_tree_store #(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  localparam int WW = $clog2(NUM_WAYS),
  localparam int SW = $clog2(NUM_SETS),
  localparam int NB = NUM_WAYS - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [SW-1:0] touch_set,
  input  logic [WW-1:0] touch_way,
  input  logic [SW-1:0] query_set,
  output logic [WW-1:0] pick_way
);
  logic [NB-1:0] tree_q [NUM_SETS];
  logic [NB-1:0] tree_nxt, tree_qry;
  logic [WW:0]   up_node, dn_node;
  logic          up_dir, dn_dir;

  // walk the touch path and point each node away
  always_comb begin
    tree_nxt = tree_q[touch_set];
    up_node  = (WW+1)'(1);
    for (int lvl = 0; lvl < WW; lvl++) begin
      up_dir                 = touch_way[WW-1-lvl];
      tree_nxt[up_node - 1'b1] = ~up_dir;
      up_node                = {up_node[WW-1:0], up_dir};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++)
        tree_q[s] <= '0;
    end else if (touch_en) begin
      tree_q[touch_set] <= tree_nxt;
    end
  end

  // follow the bits from the root
  always_comb begin
    tree_qry = tree_q[query_set];
    dn_node  = (WW+1)'(1);
    pick_way = '0;
    for (int lvl = 0; lvl < WW; lvl++) begin
      dn_dir   = tree_qry[dn_node - 1'b1];
      pick_way = {pick_way[WW-2:0], dn_dir};
      dn_node  = {dn_node[WW-1:0], dn_dir};
    end
  end
endmodule

// File: rtl/victim_select.sv
module victim_select
  import repl_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  localparam int WW = $clog2(NUM_WAYS)
) (
  input  repl_policy_e        policy,
  input  logic [NUM_WAYS-1:0] valid_vec,
  input  logic [WW-1:0]       lru_way,
  input  logic [WW-1:0]       plru_way,
  output logic [WW-1:0]       victim
);
  logic [WW-1:0] free_way;
  logic          any_free;

  always_comb begin
    free_way = '0;
    any_free = 1'b0;
    for (int w = NUM_WAYS-1; w >= 0; w--)
      if (!valid_vec[w]) begin
        free_way = WW'(w);
        any_free = 1'b1;
      end
  end

  always_comb begin
    if (any_free)                victim = free_way;
    else if (policy == POL_PLRU) victim = plru_way;
    else                         victim = lru_way;
  end
endmodule

// File: rtl/repl_unit.sv
module repl_unit
  import repl_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  localparam int WW = $clog2(NUM_WAYS),
  localparam int SW = $clog2(NUM_SETS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                policy_sel,
  input  logic                touch_valid,
  input  logic [SW-1:0]       touch_set,
  input  logic [WW-1:0]       touch_way,
  input  logic [SW-1:0]       query_set,
  input  logic [NUM_WAYS-1:0] query_valid,
  output logic [WW-1:0]       victim_way
);
  logic [WW-1:0] lru_pick, plru_pick;
  repl_policy_e  policy;

  assign policy = repl_policy_e'(policy_sel);

  lru_rank_store #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_valid),
    .touch_set(touch_set), .touch_way(touch_way),
    .query_set(query_set), .oldest_way(lru_pick)
  );

  plru_tree_store #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_plru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_valid),
    .touch_set(touch_set), .touch_way(touch_way),
    .query_set(query_set), .pick_way(plru_pick)
  );

  victim_select #(.NUM_WAYS(NUM_WAYS)) u_sel (
    .policy(policy), .valid_vec(query_valid),
    .lru_way(lru_pick), .plru_way(plru_pick), .victim(victim_way)
  );
endmodule

// File: rtl/repl_unit_chk.sv
module repl_unit_chk #(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  localparam int WW = $clog2(NUM_WAYS),
  localparam int SW = $clog2(NUM_SETS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                policy_sel,
  input logic                touch_valid,
  input logic [SW-1:0]       touch_set,
  input logic [WW-1:0]       touch_way,
  input logic [SW-1:0]       query_set,
  input logic [NUM_WAYS-1:0] query_valid,
  input logic [WW-1:0]       victim_way
);
  logic lower_all_valid;

  always_comb begin
    lower_all_valid = 1'b1;
    for (int w = 0; w < NUM_WAYS; w++)
      if (WW'(w) < victim_way && !query_valid[w]) lower_all_valid = 1'b0;
  end

  p_policy_static_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(policy_sel));

  p_free_way_chosen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (~&query_valid) |-> !query_valid[victim_way]);

  p_lowest_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (~&query_valid) |-> lower_all_valid);

  p_no_recent_victim_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(touch_valid) && (&query_valid)
     && query_set == $past(touch_set)) |-> victim_way != $past(touch_way));
endmodule

bind repl_unit repl_unit_chk #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_chk (
  .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel),
  .touch_valid(touch_valid), .touch_set(touch_set), .touch_way(touch_way),
  .query_set(query_set), .query_valid(query_valid), .victim_way(victim_way)
);

// File: tb/repl_unit_tb.sv
module repl_unit_tb;
  localparam int WAYS = 4;
  localparam int SETS = 16;
  localparam int WW   = $clog2(WAYS);
  localparam int SW   = $clog2(SETS);

  logic            clk = 1'b0;
  logic            rst_n;
  logic            policy_sel;
  logic            touch_valid;
  logic [SW-1:0]   touch_set;
  logic [WW-1:0]   touch_way;
  logic [SW-1:0]   query_set;
  logic [WAYS-1:0] query_valid;
  logic [WW-1:0]   victim_way;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  int m_rank [SETS][WAYS];
  bit m_tree [SETS][WAYS];

  always #10 clk = ~clk;

  repl_unit #(.NUM_WAYS(WAYS), .NUM_SETS(SETS)) u_dut (
    .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel),
    .touch_valid(touch_valid), .touch_set(touch_set), .touch_way(touch_way),
    .query_set(query_set), .query_valid(query_valid), .victim_way(victim_way)
  );

  task automatic model_reset();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_rank[s][w] = w;
        m_tree[s][w] = 1'b0;
      end
  endtask

  task automatic model_touch(int s, int w);
    int t;
    int node;
    int d;
    t = m_rank[s][w];
    for (int i = 0; i < WAYS; i++)
      if (i == w) m_rank[s][i] = 0;
      else if (m_rank[s][i] < t) m_rank[s][i] = m_rank[s][i] + 1;
    node = 1;
    for (int lvl = WW-1; lvl >= 0; lvl--) begin
      d = (w >> lvl) & 1;
      m_tree[s][node] = (d == 0);
      node = 2*node + d;
    end
  endtask

  function automatic int exp_victim(int s, logic [WAYS-1:0] v, bit pol);
    int node;
    int way;
    int d;
    for (int w = 0; w < WAYS; w++)
      if (!v[w]) return w;
    if (!pol) begin
      for (int w = 0; w < WAYS; w++)
        if (m_rank[s][w] == WAYS-1) return w;
      return 0;
    end
    node = 1;
    way  = 0;
    for (int lvl = 0; lvl < WW; lvl++) begin
      d    = m_tree[s][node] ? 1 : 0;
      way  = 2*way + d;
      node = 2*node + d;
    end
    return way;
  endfunction

  task automatic score(string tag, int got, int exp);
    n_vec++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: victim_way=%0d expected %0d", tag, got, exp);
    end
  endtask

  // drive on falling edge, compare 1 ns later, commit touch after rising edge
  task automatic step(string tag, bit tv, int ts, int tw, int qs, logic [WAYS-1:0] qv);
    @(negedge clk);
    touch_valid = tv;
    touch_set   = SW'(ts);
    touch_way   = WW'(tw);
    query_set   = SW'(qs);
    query_valid = qv;
    #1;
    score(tag, int'(victim_way), exp_victim(qs, qv, policy_sel));
    @(posedge clk);
    if (tv) model_touch(ts, tw);
  endtask

  task automatic do_reset(bit pol);
    @(negedge clk);
    rst_n       = 1'b0;
    policy_sel  = pol;
    touch_valid = 1'b0;
    touch_set   = '0;
    touch_way   = '0;
    query_set   = '0;
    query_valid = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic random_run(bit pol, int count);
    for (int i = 0; i < count; i++) begin
      bit              tv;
      int              ts;
      int              tw;
      int              qs;
      logic [WAYS-1:0] qv;
      tv = ($urandom % 4) != 0;
      ts = $urandom % SETS;
      tw = $urandom % WAYS;
      qs = (($urandom % 2) != 0) ? ts : ($urandom % SETS);
      qv = (($urandom % 4) == 0) ? WAYS'($urandom) : '1;
      step((&qv) ? (pol ? "R6 random" : "R3 random") : "R2 random", tv, ts, tw, qs, qv);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;

    // LRU phase (R1: select 0)
    do_reset(1'b0);
    step("R7 lru reset set0", 0, 0, 0, 0, '1);
    step("R7 lru reset set9", 0, 0, 0, 9, '1);
    step("R2 mask 1011", 0, 0, 0, 4, 4'b1011);
    step("R2 mask 0000", 0, 0, 0, 4, 4'b0000);
    step("R3 touch 3", 1, 3, 3, 3, '1);
    step("R8 same-cycle old state", 1, 3, 2, 3, '1);
    step("R10 after touch 2", 1, 3, 0, 3, '1);
    step("R3 after 3,2,0", 1, 3, 1, 3, '1);
    step("R3 oldest is 3", 0, 0, 0, 3, '1);
    step("R9 no-valid touch", 0, 3, 3, 3, '1);
    step("R9 state kept", 0, 0, 0, 3, '1);
    step("R4 rehit 2", 1, 3, 2, 3, '1);
    step("R4 after rehit", 0, 0, 0, 3, '1);
    step("R4 other set untouched", 0, 0, 0, 7, '1);
    random_run(1'b0, 400);

    // PLRU phase (R1: select 1)
    do_reset(1'b1);
    step("R7 plru reset", 0, 0, 0, 0, '1);
    step("R5 touch 0", 1, 2, 0, 2, '1);
    step("R6 after touch 0", 1, 2, 2, 2, '1);
    step("R6 after touch 2", 0, 0, 0, 2, '1);
    step("R9 plru no-valid touch", 0, 2, 1, 2, '1);
    step("R10 plru touch 1", 1, 2, 1, 2, '1);
    step("R10 plru after 1", 0, 0, 0, 2, '1);
    step("R2 plru mask 0111", 0, 0, 0, 2, 4'b0111);
    step("R5 other set untouched", 0, 0, 0, 5, '1);
    random_run(1'b1, 400);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule